// File: doc/BRIEF.md
# Dependency-Vector Issue Scheduler

This block sits between instruction fetch and a row of untyped execution units in a wide-word machine. Every cycle it may take one packed long word. The word holds one slot per unit, and each slot carries an operation code, an execute latency, and two small bit vectors. The pre vector names the units whose earlier work this operation needs. The post vector names the units that will later consume this operation's result.

Each valid slot goes into a short queue owned by its unit, and each unit then runs on its own. A unit starts its head operation once it is free and every producer named in the pre vector has signalled completion. A unit may also start in the cycle its current operation finishes. Completions travel as tokens. There is one small saturating counter for every ordered pair of units. A finishing producer adds a token to each counter its post vector names, and an issuing consumer takes one token from each counter its pre vector names. Operations that arrived in different long words can therefore execute in the same cycle.

Top module: `dep_issue_sched`

## Requirements
- R1: A synchronous active-high `rst` empties every queue, clears every unit's execute state and zeroes every token counter. In the first cycle after reset `inReady` is 1 and no `issueValid` or `doneValid` bit is set.
- R2: Slot u of `inWord` occupies bits [u*15 +: 15]. Within a slot, bit 14 is valid, bits 13:6 are the operation code, bits 5:4 are the latency code, bits 3:2 are the pre vector and bits 1:0 are the post vector. A slot whose valid bit is 0 is not queued, never issues and produces no tokens.
- R3: Each unit's queue holds 4 operations. `inReady` is 0 exactly when at least one queue holds 4. A word is taken when `inValid` and `inReady` are both 1, and all of its valid slots are queued in that cycle.
- R4: A unit issues its head operation (`issueValid` bit set, code on `issueOp`) only if, for every set pre bit, the counter from the named producer to this unit is non-zero. The issue removes one token from each such counter.
- R5: An operation with latency code L shows `doneValid`, with its code on `doneOp`, for exactly one cycle, L+1 cycles after its issue cycle.
- R6: A unit holds at most one operation in execute. It may issue its next operation in the same cycle that its current operation shows `doneValid`.
- R7: Each unit issues its operations in the order it accepted them.
- R8: A completion whose post vector names unit c adds a token from the producer to c. The earliest a consumer waiting on that token can issue is the cycle after the producer's `doneValid`.
- R9: A token counter saturates at 3. Tokens that arrive while it holds 3 are lost.
- R10: Bit k of a vector that belongs to unit j names unit k when k < j and unit k+1 otherwise.
- R11: Units issue independently. An operation may issue while another unit is stalled on tokens or is still executing an operation from an earlier word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A long word is offered |
| inWord | input | 45 | Packed long word, one 15-bit slot per unit |
| inReady | output | 1 | Every queue can take a slot this cycle |
| issueValid | output | 3 | Per-unit issue strobe |
| issueOp | output | 24 | Per-unit operation code being issued, 8 bits per unit |
| doneValid | output | 3 | Per-unit completion strobe |
| doneOp | output | 24 | Per-unit operation code completing, 8 bits per unit |

## Verification
A word taken at the end of cycle t can issue combinationally in cycle t+1. If it issues in cycle i, its `doneValid` is due in cycle i+L+1. A token from that completion can release a consumer no earlier than the following cycle. The bench steps a cycle-level model in the same procedure that drives the inputs. It drives each cycle's inputs just after the falling edge and compares `inReady`, `issueValid`/`issueOp` and `doneValid`/`doneOp` 2 ns later, so every comparison falls before the rising edge that commits that cycle's decisions. The directed cases also check hand-counted issue and completion cycle numbers, without using the model.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int NUM_UNITS = 3;
  localparam int VEC_W     = NUM_UNITS - 1;
  localparam int OP_W      = 8;
  localparam int LAT_W     = 2;
  localparam int Q_DEPTH   = 4;   // power of two: pointers wrap naturally
  localparam int Q_AW      = $clog2(Q_DEPTH);
  localparam int CNT_W     = 2;
  localparam int CNT_MAX   = (1 << CNT_W) - 1;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [LAT_W-1:0] lat;
    logic [VEC_W-1:0] pre;
    logic [VEC_W-1:0] post;
  } qent_t;

  typedef struct packed {
    logic  vld;
    qent_t body;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  typedef struct packed {
    logic [NUM_UNITS-1:0] enq;
    logic [NUM_UNITS-1:0] issue;
  } strobe_t;

  // vector bit k of unit self -> unit index it names
  function automatic int otherUnit(int self, int k);
    return (k < self) ? k : k + 1;
  endfunction

  // unit index other -> vector bit inside unit self's vectors
  function automatic int vecBit(int self, int other);
    return (other < self) ? other : other - 1;
  endfunction
endpackage

// File: rtl/dis_datapath.sv
module dis_datapath
  import dis_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst,
  input  strobe_t                               stb,
  input  qent_t [NUM_UNITS-1:0]                 slotBody,
  output logic  [NUM_UNITS-1:0][OP_W-1:0]       headOp,
  output logic  [NUM_UNITS-1:0][VEC_W-1:0]      headPre,
  output logic  [NUM_UNITS-1:0]                 headValid,
  output logic  [NUM_UNITS-1:0]                 qFull,
  output logic  [NUM_UNITS-1:0]                 busy,
  output logic  [NUM_UNITS-1:0]                 doneNow,
  output logic  [NUM_UNITS-1:0][OP_W-1:0]       curOp,
  output logic  [NUM_UNITS-1:0][NUM_UNITS-1:0]  tokenAvail
);
  logic [NUM_UNITS-1:0][VEC_W-1:0] curPost;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    qent_t            mem [Q_DEPTH];
    qent_t            head;
    logic [Q_AW-1:0]  rdPtr, wrPtr;
    logic [Q_AW:0]    count;
    logic             run;
    logic [LAT_W-1:0] rem;
    logic [OP_W-1:0]  op;
    logic [VEC_W-1:0] post;

    always_ff @(posedge clk) begin
      if (stb.enq[u]) mem[wrPtr] <= slotBody[u];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rdPtr <= '0;
        wrPtr <= '0;
        count <= '0;
      end else begin
        if (stb.enq[u])   wrPtr <= wrPtr + 1'b1;
        if (stb.issue[u]) rdPtr <= rdPtr + 1'b1;
        count <= count + (Q_AW+1)'(stb.enq[u]) - (Q_AW+1)'(stb.issue[u]);
      end
    end

    assign head         = mem[rdPtr];
    assign headOp[u]    = head.op;
    assign headPre[u]   = head.pre;
    assign headValid[u] = (count != '0);
    assign qFull[u]     = (count == (Q_AW+1)'(Q_DEPTH));

    // fixed-latency execute slot
    always_ff @(posedge clk) begin
      if (rst) begin
        run <= 1'b0;
      end else if (stb.issue[u]) begin
        run  <= 1'b1;
        rem  <= head.lat;
        op   <= head.op;
        post <= head.post;
      end else if (doneNow[u]) begin
        run <= 1'b0;
      end else if (run) begin
        rem <= rem - 1'b1;
      end
    end

    assign busy[u]    = run;
    assign doneNow[u] = run && (rem == '0);
    assign curOp[u]   = op;
    assign curPost[u] = post;
  end

  // token counter for every ordered (producer, consumer) pair
  for (genvar p = 0; p < NUM_UNITS; p++) begin : g_prod
    for (genvar c = 0; c < NUM_UNITS; c++) begin : g_cons
      if (p == c) begin : g_self
        assign tokenAvail[p][c] = 1'b0;
      end else begin : g_pair
        localparam int PostBit = vecBit(p, c);
        localparam int PreBit  = vecBit(c, p);
        logic [CNT_W-1:0] cnt;
        logic inc, dec;
        assign inc = doneNow[p] && curPost[p][PostBit];
        assign dec = stb.issue[c] && headPre[c][PreBit];
        always_ff @(posedge clk) begin
          if (rst)                                         cnt <= '0;
          else if (inc && !dec && cnt != CNT_W'(CNT_MAX))  cnt <= cnt + 1'b1;
          else if (dec && !inc)                            cnt <= cnt - 1'b1;
        end
        assign tokenAvail[p][c] = (cnt != '0);
      end
    end
  end
endmodule

// File: rtl/dis_control.sv
module dis_control
  import dis_pkg::*;
(
  input  logic                                 inValid,
  input  logic  [NUM_UNITS-1:0]                slotVld,
  input  logic  [NUM_UNITS-1:0]                headValid,
  input  logic  [NUM_UNITS-1:0][VEC_W-1:0]     headPre,
  input  logic  [NUM_UNITS-1:0]                busy,
  input  logic  [NUM_UNITS-1:0]                doneNow,
  input  logic  [NUM_UNITS-1:0]                qFull,
  input  logic  [NUM_UNITS-1:0][NUM_UNITS-1:0] tokenAvail,
  output strobe_t                              stb,
  output logic                                 inReady
);
  logic [NUM_UNITS-1:0] depsMet;

  always_comb begin
    inReady = ~|qFull;
    depsMet = '1;
    for (int u = 0; u < NUM_UNITS; u++) begin
      for (int k = 0; k < VEC_W; k++) begin
        if (headPre[u][k] && !tokenAvail[otherUnit(u, k)][u]) depsMet[u] = 1'b0;
      end
      stb.enq[u]   = inValid && inReady && slotVld[u];
      stb.issue[u] = headValid[u] && (!busy[u] || doneNow[u]) && depsMet[u];
    end
  end
endmodule

// File: rtl/dep_issue_sched.sv
module dep_issue_sched
  import dis_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic [NUM_UNITS*SLOT_W-1:0] inWord,
  output logic                        inReady,
  output logic [NUM_UNITS-1:0]        issueValid,
  output logic [NUM_UNITS*OP_W-1:0]   issueOp,
  output logic [NUM_UNITS-1:0]        doneValid,
  output logic [NUM_UNITS*OP_W-1:0]   doneOp
);
  slot_t   [NUM_UNITS-1:0]                slotIn;
  qent_t   [NUM_UNITS-1:0]                slotBody;
  logic    [NUM_UNITS-1:0]                slotVld;
  strobe_t                                stb;
  logic    [NUM_UNITS-1:0][OP_W-1:0]      headOp, curOp;
  logic    [NUM_UNITS-1:0][VEC_W-1:0]     headPre;
  logic    [NUM_UNITS-1:0]                headValid, qFull, busy, doneNow;
  logic    [NUM_UNITS-1:0][NUM_UNITS-1:0] tokenAvail;

  assign slotIn = inWord;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_split
    assign slotBody[u] = slotIn[u].body;
    assign slotVld[u]  = slotIn[u].vld;
  end

  dis_control u_ctrl (
    .inValid(inValid), .slotVld(slotVld), .headValid(headValid), .headPre(headPre),
    .busy(busy), .doneNow(doneNow), .qFull(qFull), .tokenAvail(tokenAvail),
    .stb(stb), .inReady(inReady)
  );

  dis_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .slotBody(slotBody), .headOp(headOp),
    .headPre(headPre), .headValid(headValid), .qFull(qFull), .busy(busy),
    .doneNow(doneNow), .curOp(curOp), .tokenAvail(tokenAvail)
  );

  assign issueValid = stb.issue;
  assign issueOp    = headOp;
  assign doneValid  = doneNow;
  assign doneOp     = curOp;
endmodule

// File: rtl/dis_checker.sv
module dis_checker
  import dis_pkg::*;
(
  input logic                                 clk,
  input logic                                 rst,
  input logic [NUM_UNITS-1:0]                 issueValid,
  input logic [NUM_UNITS-1:0]                 doneValid,
  input logic                                 inReady,
  input logic [NUM_UNITS-1:0]                 busy,
  input logic [NUM_UNITS-1:0]                 qFull,
  input logic [NUM_UNITS-1:0][NUM_UNITS-1:0]  tokenAvail,
  input logic [NUM_UNITS-1:0][VEC_W-1:0]      headPre
);
  p_full_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    (|qFull) |-> !inReady);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
    p_issue_idle_r6: assert property (@(posedge clk) disable iff (rst)
      issueValid[u] |-> (!busy[u] || doneValid[u]));

    p_issue_starts_exec_r5: assert property (@(posedge clk) disable iff (rst)
      issueValid[u] |=> busy[u]);

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
      (doneValid[u] && !issueValid[u]) |=> !doneValid[u]);

    for (genvar k = 0; k < VEC_W; k++) begin : g_bit
      localparam int Src = otherUnit(u, k);
      p_tokens_present_r4: assert property (@(posedge clk) disable iff (rst)
        (issueValid[u] && headPre[u][k]) |-> tokenAvail[Src][u]);
    end
  end
endmodule

bind dep_issue_sched dis_checker u_chk (
  .clk(clk), .rst(rst), .issueValid(issueValid), .doneValid(doneValid),
  .inReady(inReady), .busy(busy), .qFull(qFull), .tokenAvail(tokenAvail),
  .headPre(headPre)
);

// File: tb/tb_dep_issue_sched.sv
`timescale 1ns/1ps
module tb_dep_issue_sched;
  import dis_pkg::*;
  localparam int NU = NUM_UNITS;

  logic clk = 1'b0, rst = 1'b1, inValid = 1'b0;
  logic [NU*SLOT_W-1:0] inWord = '0;
  logic inReady;
  logic [NU-1:0] issueValid, doneValid;
  logic [NU*OP_W-1:0] issueOp, doneOp;

  dep_issue_sched dut (.clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .issueValid(issueValid), .issueOp(issueOp),
    .doneValid(doneValid), .doneOp(doneOp));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // reference model state
  qent_t            mQ [NU][Q_DEPTH];
  int               mN [NU];
  logic             mBusy [NU];
  int               mRem [NU];
  logic [OP_W-1:0]  mOp [NU];
  logic [VEC_W-1:0] mPost [NU];
  int               mCnt [NU][NU];
  logic             mAcc;
  int cyc, dutDones, mDones;
  int issueCnt [NU], doneCnt [NU];
  int issueCyc [NU][8], doneCyc [NU][8];
  logic [OP_W-1:0] issueLog [NU][8];
  logic sawNotReady;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc %0d: act %0h exp %0h", req, cyc, act, exp);
    end
  endtask

  function automatic slot_t mk(logic v, logic [OP_W-1:0] op, logic [LAT_W-1:0] lat,
                               logic [VEC_W-1:0] pre, logic [VEC_W-1:0] post);
    slot_t s;
    s.vld = v; s.body.op = op; s.body.lat = lat; s.body.pre = pre; s.body.post = post;
    return s;
  endfunction

  task automatic modelClear();
    for (int u = 0; u < NU; u++) begin
      mN[u] = 0; mBusy[u] = 1'b0; mRem[u] = 0;
      issueCnt[u] = 0; doneCnt[u] = 0;
      for (int v = 0; v < NU; v++) mCnt[u][v] = 0;
    end
    cyc = 0; sawNotReady = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0; inWord = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelClear();
    #2;
    chk(inReady === 1'b1, "R1 ready", inReady, 1);
    chk(issueValid === '0, "R1 issue", issueValid, 0);
    chk(doneValid === '0, "R1 done", doneValid, 0);
    @(negedge clk);
  endtask

  // one cycle: drive, compare against the model, advance the model
  task automatic step(input logic v, input slot_t [NU-1:0] w);
    logic [NU-1:0] eIss, eDone;
    logic eRdy;
    inValid = v; inWord = w;
    #2;
    eRdy = 1'b1;
    for (int u = 0; u < NU; u++) if (mN[u] == Q_DEPTH) eRdy = 1'b0;
    for (int u = 0; u < NU; u++) begin
      eDone[u] = mBusy[u] && (mRem[u] == 0);
      eIss[u]  = (mN[u] != 0) && (!mBusy[u] || eDone[u]);
      if (mN[u] != 0)
        for (int k = 0; k < VEC_W; k++)
          if (mQ[u][0].pre[k] && mCnt[otherUnit(u, k)][u] == 0) eIss[u] = 1'b0;
    end
    chk(inReady === eRdy, "R3 ready", inReady, eRdy);
    if (!inReady) sawNotReady = 1'b1;
    for (int u = 0; u < NU; u++) begin
      chk(issueValid[u] === eIss[u], "R4 issue", issueValid[u], eIss[u]);
      if (eIss[u]) chk(issueOp[u*OP_W +: OP_W] === mQ[u][0].op, "R7 issueOp",
                       issueOp[u*OP_W +: OP_W], mQ[u][0].op);
      chk(doneValid[u] === eDone[u], "R5 done", doneValid[u], eDone[u]);
      if (eDone[u]) chk(doneOp[u*OP_W +: OP_W] === mOp[u], "R5 doneOp",
                        doneOp[u*OP_W +: OP_W], mOp[u]);
      if (issueValid[u]) begin
        if (issueCnt[u] < 8) begin
          issueCyc[u][issueCnt[u]] = cyc;
          issueLog[u][issueCnt[u]] = issueOp[u*OP_W +: OP_W];
        end
        issueCnt[u]++;
      end
      if (doneValid[u]) begin
        if (doneCnt[u] < 8) doneCyc[u][doneCnt[u]] = cyc;
        doneCnt[u]++; dutDones++;
      end
      if (eDone[u]) mDones++;
    end
    // token counters
    for (int p = 0; p < NU; p++)
      for (int c = 0; c < NU; c++)
        if (p != c) begin
          logic inc, dec;
          inc = eDone[p] && mPost[p][vecBit(p, c)];
          dec = eIss[c] && mQ[c][0].pre[vecBit(c, p)];
          if (inc && !dec && mCnt[p][c] < CNT_MAX) mCnt[p][c]++;
          else if (dec && !inc) mCnt[p][c]--;
        end
    // execute slots and queues
    for (int u = 0; u < NU; u++) begin
      if (eIss[u]) begin
        mBusy[u] = 1'b1; mRem[u] = mQ[u][0].lat;
        mOp[u] = mQ[u][0].op; mPost[u] = mQ[u][0].post;
        for (int i = 0; i < Q_DEPTH - 1; i++) mQ[u][i] = mQ[u][i+1];
        mN[u]--;
      end else if (eDone[u]) mBusy[u] = 1'b0;
      else if (mBusy[u]) mRem[u]--;
      if (v && eRdy && w[u].vld) begin
        mQ[u][mN[u]] = w[u].body; mN[u]++;
      end
    end
    mAcc = v && eRdy;
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    slot_t [NU-1:0] z;
    z = '0;
    for (int i = 0; i < n; i++) step(1'b0, z);
  endtask

  task automatic send(input slot_t [NU-1:0] w);
    do step(1'b1, w); while (!mAcc);
  endtask

  int pending [NU][NU];

  initial begin
    slot_t [NU-1:0] w;
    int rnd;
    dutDones = 0; mDones = 0;
    rnd = $urandom(32'h5eed1234);
    @(negedge clk);
    doReset();

    // R8 R10: unit0 posts to unit2 (post bit1), unit2 waits on unit0 (pre bit0)
    w = '0;
    w[0] = mk(1'b1, 8'h11, 2'd2, 2'b00, 2'b10);
    w[2] = mk(1'b1, 8'h22, 2'd0, 2'b01, 2'b00);
    step(1'b1, w);
    idle(8);
    chk(issueCyc[0][0] == 1, "R5 producer issue", issueCyc[0][0], 1);
    chk(doneCyc[0][0] == 4, "R5 producer done", doneCyc[0][0], 4);
    chk(issueCyc[2][0] == 5, "R8 R10 consumer issue", issueCyc[2][0], 5);
    chk(doneCyc[2][0] == 6, "R5 consumer done", doneCyc[2][0], 6);

    // R6 R11: back-to-back issue on unit1 while unit0 still executes
    doReset();
    w = '0;
    w[0] = mk(1'b1, 8'hA0, 2'd3, 2'b00, 2'b00);
    w[1] = mk(1'b1, 8'hB0, 2'd0, 2'b00, 2'b00);
    step(1'b1, w);
    w = '0;
    w[1] = mk(1'b1, 8'hB1, 2'd0, 2'b00, 2'b00);
    step(1'b1, w);
    idle(8);
    chk(issueCyc[1][1] == 2, "R6 R11 reissue", issueCyc[1][1], 2);
    chk(doneCyc[0][0] == 5, "R5 long latency", doneCyc[0][0], 5);
    chk(issueLog[1][1] == 8'hB1, "R7 order", issueLog[1][1], 8'hB1);

    // R2: invalid slot ignored
    doReset();
    w = '0;
    w[1] = mk(1'b0, 8'hEE, 2'd0, 2'b00, 2'b11);
    w[0] = mk(1'b1, 8'h01, 2'd0, 2'b00, 2'b00);
    step(1'b1, w);
    idle(6);
    chk(issueCnt[1] == 0, "R2 nop issue", issueCnt[1], 0);
    chk(doneCnt[0] == 1, "R2 valid slot done", doneCnt[0], 1);

    // R9: four tokens into a 3-limit counter, five consumers
    doReset();
    for (int i = 0; i < 4; i++) begin
      w = '0;
      w[0] = mk(1'b1, 8'(8'h40 + i), 2'd0, 2'b00, 2'b01);
      send(w);
    end
    idle(6);
    for (int i = 0; i < 5; i++) begin
      w = '0;
      w[1] = mk(1'b1, 8'(8'h50 + i), 2'd0, 2'b01, 2'b00);
      send(w);
    end
    idle(10);
    chk(issueCnt[1] == 3, "R9 saturation", issueCnt[1], 3);

    // R3: fill unit0 queue with slow operations
    doReset();
    for (int i = 0; i < 7; i++) begin
      w = '0;
      w[0] = mk(1'b1, 8'(8'h60 + i), 2'd3, 2'b00, 2'b00);
      send(w);
    end
    chk(sawNotReady == 1'b1, "R3 backpressure", sawNotReady, 1);
    idle(40);
    chk(doneCnt[0] == 7, "R3 all drained", doneCnt[0], 7);

    // random traffic, dependency-consistent in program order
    doReset();
    dutDones = 0; mDones = 0;
    for (int p = 0; p < NU; p++) for (int c = 0; c < NU; c++) pending[p][c] = 0;
    for (int n = 0; n < 300; n++) begin
      w = '0;
      for (int u = 0; u < NU; u++) begin
        if ($urandom % 4 != 0) begin
          w[u].vld = 1'b1;
          w[u].body.op = 8'($urandom);
          w[u].body.lat = 2'($urandom % 4);
          for (int p = 0; p < NU; p++)
            if (p != u && pending[p][u] > 0 && $urandom % 2 == 0) begin
              w[u].body.pre[vecBit(u, p)] = 1'b1; pending[p][u]--;
            end
          for (int c = 0; c < NU; c++)
            if (c != u && pending[u][c] == 0 && $urandom % 3 == 0) begin
              w[u].body.post[vecBit(u, c)] = 1'b1; pending[u][c]++;
            end
        end
      end
      if ($urandom % 5 == 0) idle(1);
      send(w);
    end
    idle(200);
    chk(dutDones == mDones, "R8 total completions", dutDones, mDones);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule